// File: doc/BRIEF.md
# Streaming Word Checksum with Request Handshake

This block keeps a running arithmetic checksum over a stream of input words. A word is folded into the sum in every cycle its valid strobe is high. Between messages a clear pulse restarts the sum. When the owner of the stream wants the result, it pulses a request. One clock later the block presents the checksum together with a single-cycle valid strobe.

Three parameters shape the arithmetic. The input word width and the checksum width are set independently. A mode parameter chooses how each word is widened before it is added: sign-extended in signed mode, zero-extended in unsigned mode. The sum wraps modulo two to the power of the checksum width. If the checksum is narrower than the input word, only the low bits of each word are used.

Top module: `csum_unit`

## Requirements
- R1: While reset is asserted and after its release, `sumOut` reads 0 and `sumValid` is low until the first request.
- R2: A word changes the running sum only in a cycle where `dataValid` is high. Words presented with `dataValid` low have no effect on any later reported value.
- R3: With `SIGNED_SUM` = 0, each word is zero-extended to `SUM_W` bits before it is added. For example, 8-bit 0xFF adds 255.
- R4: With `SIGNED_SUM` = 1, each word is sign-extended to `SUM_W` bits before it is added. For example, 8-bit 0xFF adds -1, which is 0xFFFF in 16 bits.
- R5: The running sum wraps modulo 2^`SUM_W`.
- R6: A cycle with `clearSum` high and `dataValid` low leaves the running sum at 0.
- R7: A cycle with both `clearSum` and `dataValid` high leaves the running sum equal to that cycle's extended word.
- R8: `sumValid` is high for exactly one cycle, in the cycle after a cycle where `reqSum` is high, and is low at all other times.
- R9: The reported value is the running sum after the request cycle's own update. This includes a word or a clear presented in that same cycle.
- R10: `sumOut` keeps the last reported value in every cycle in which `sumValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | DATA_W | Input word |
| dataValid | input | 1 | Adds `dataIn` to the sum this cycle |
| clearSum | input | 1 | Restarts the running sum |
| reqSum | input | 1 | Requests the checksum |
| sumOut | output | SUM_W | Reported checksum |
| sumValid | output | 1 | One-cycle strobe marking a fresh `sumOut` |

## Verification
The same stimulus drives one signed instance and one unsigned instance. Words with the top bit set therefore give different results in the two modes, which separates sign extension from zero extension.

The stimulus includes several kinds of gaps and overlaps:
- idle gaps in which garbage is presented with the valid strobe low;
- requests back to back;
- a request arriving together with a word or with a clear;
- a clear arriving together with a word.

Together these show whether the same-cycle word is included and whether a clear restarts at zero or at the new word. A long run of 0xFF words pushes both sums past the 16-bit limit, which checks the wrap.

// File: rtl/csum_pkg.sv
package csum_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic clear;    // restart the running sum
    logic add;      // fold the current word in
    logic capture;  // load the reporting register
  } csumStrobe_t;
endpackage

// File: rtl/csum_ctrl.sv
module csum_ctrl
  import csum_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dataValid,
  input  logic        clearSum,
  input  logic        reqSum,
  output csumStrobe_t strobe,
  output logic        sumValid
);

  always_comb begin
    strobe.clear   = clearSum;
    strobe.add     = dataValid;
    strobe.capture = reqSum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sumValid <= 1'b0;
    else       sumValid <= reqSum;
  end

  // R8
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqSum |=> sumValid);
  // R8
  valid_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    sumValid |-> $past(reqSum));

endmodule

// File: rtl/csum_datapath.sv
module csum_datapath
  import csum_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SUM_W      = 16,
  parameter bit SIGNED_SUM = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  csumStrobe_t       strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic [SUM_W-1:0]  sumOut
);

  localparam int PAD_W = (SUM_W > DATA_W) ? SUM_W - DATA_W : 1;

  logic [SUM_W-1:0] wordExt;
  logic [SUM_W-1:0] accQ;
  logic [SUM_W-1:0] accNext;

  generate
    if (SUM_W > DATA_W) begin : g_widen
      logic padBit;
      if (SIGNED_SUM) begin : g_sign
        assign padBit = dataIn[DATA_W-1];
      end else begin : g_zero
        assign padBit = 1'b0;
      end
      assign wordExt = {{PAD_W{padBit}}, dataIn};
    end else begin : g_trunc
      assign wordExt = dataIn[SUM_W-1:0];
    end
  endgenerate

  always_comb begin
    accNext = accQ;
    if (strobe.clear) accNext = strobe.add ? wordExt : '0;
    else if (strobe.add) accNext = accQ + wordExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= '0;
      sumOut <= '0;
    end else begin
      accQ <= accNext;
      if (strobe.capture) sumOut <= accNext;
    end
  end

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clear && !strobe.add) |=> (accQ == '0));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.add) |=> $stable(accQ));
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(sumOut));

endmodule

// File: rtl/csum_unit.sv
module csum_unit
  import csum_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SUM_W      = 16,
  parameter bit SIGNED_SUM = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataValid,
  input  logic              clearSum,
  input  logic              reqSum,
  output logic [SUM_W-1:0]  sumOut,
  output logic              sumValid
);

  csumStrobe_t strobe;

  csum_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dataValid(dataValid), .clearSum(clearSum),
    .reqSum(reqSum), .strobe(strobe), .sumValid(sumValid)
  );

  csum_datapath #(.DATA_W(DATA_W), .SUM_W(SUM_W), .SIGNED_SUM(SIGNED_SUM)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn), .sumOut(sumOut)
  );

endmodule

// File: tb/csum_unit_bench.sv
module csum_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] dataIn = '0;
  logic dataValid = 1'b0, clearSum = 1'b0, reqSum = 1'b0;
  logic [15:0] sumS, sumU;
  logic validS, validU;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  csum_unit #(.DATA_W(8), .SUM_W(16), .SIGNED_SUM(1'b1)) u_csum_unit (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dataValid(dataValid),
    .clearSum(clearSum), .reqSum(reqSum), .sumOut(sumS), .sumValid(validS));
  csum_unit #(.DATA_W(8), .SUM_W(16), .SIGNED_SUM(1'b0)) u_csum_unit_u (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dataValid(dataValid),
    .clearSum(clearSum), .reqSum(reqSum), .sumOut(sumU), .sumValid(validU));

  // Each entry: {clear, valid, req, data[7:0]}
  localparam int NV = 18;
  localparam logic [10:0] VEC [NV] = '{
    {3'b010, 8'h05}, {3'b010, 8'h80}, {3'b001, 8'h00},  // R3 R4: 0x80 differs per mode
    {3'b000, 8'hAA}, {3'b001, 8'h33},                   // R2: idle garbage ignored
    {3'b011, 8'hFF}, {3'b001, 8'h00},                   // R9: same-cycle word counted
    {3'b100, 8'h77}, {3'b001, 8'h00},                   // R6: clear without word
    {3'b110, 8'hF0}, {3'b010, 8'h01}, {3'b001, 8'h00},  // R7: clear with word
    {3'b111, 8'h81}, {3'b000, 8'h00},                   // R9: clear+word+req together
    {3'b101, 8'h11}, {3'b010, 8'h7F}, {3'b011, 8'h7F}, {3'b000, 8'h00}
  };

  logic [15:0] modS = '0, modU = '0, expS = '0, expU = '0;
  bit lastReq = 0;

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Sample outputs for the previous step, then apply a new step
  task automatic step(input bit c, input bit v, input bit r, input logic [7:0] d);
    @(negedge clk);
    chk(validS == lastReq, "R8 signed valid", 16'(validS), 16'(lastReq));
    chk(validU == lastReq, "R8 unsigned valid", 16'(validU), 16'(lastReq));
    chk(sumS == expS, lastReq ? "R9 signed value" : "R10 signed hold", sumS, expS);
    chk(sumU == expU, lastReq ? "R9 unsigned value" : "R10 unsigned hold", sumU, expU);
    clearSum = c; dataValid = v; reqSum = r; dataIn = d;
    if (c) begin
      modS = v ? {{8{d[7]}}, d} : 16'h0;
      modU = v ? {8'h00, d} : 16'h0;
    end else if (v) begin
      modS = modS + {{8{d[7]}}, d};
      modU = modU + {8'h00, d};
    end
    if (r) begin expS = modS; expU = modU; end
    lastReq = r;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(sumS == 0 && !validS, "R1 signed reset", sumS, 16'h0);
    chk(sumU == 0 && !validU, "R1 unsigned reset", sumU, 16'h0);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) step(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0]);
    // R5: wrap past 16 bits with a long run of 0xFF words
    step(1'b1, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 1'b0, 8'hFF);
    step(1'b0, 1'b0, 1'b1, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    chk(expU == 16'd10964, "R5 unsigned wrap", sumU, 16'd10964);
    chk(expS == 16'd65236, "R5 signed wrap", sumS, 16'd65236);
    // R8: back-to-back requests
    step(1'b0, 1'b1, 1'b1, 8'h02);
    step(1'b0, 1'b1, 1'b1, 8'h03);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule